// File: doc/BRIEF.md
# DAC Control Register Bank with Non-Volatile Write Sequencing

This block holds the control page of a voltage-output DAC: the live 12-bit DAC code, a stored start-up copy of that code, a configuration byte that selects the full-scale level, the zero-scale level and the up/down step size, and a volatile steering flag. A serial front end forwards each received byte with its register offset inside the page, marks the end of every transaction, and issues one-cycle reads. Writes are held in a staging stage and take effect only when the transaction closes and its byte pattern is legal. Illegal patterns leave every register as it was.

Writes to the stored copy or to the configuration byte model a self-timed non-volatile programming cycle. A busy flag stays high for a fixed number of clock cycles, and any write transaction seen while it is high is discarded. A recall strobe, standing in for power-up, copies the stored code into the live DAC code and clears the steering flag.

Top module: `dac_regbank`

## Requirements
- R1: After reset the DAC code is 000h, the configuration byte is 84h (full-scale select 3'b100 from bits 7:5, zero-scale select 3'b001 from bits 4:2, step select 2'b00 from bits 1:0), the steering flag is 0 and the busy flag is 0.
- R2: With the steering flag at 0, a transaction of exactly two bytes, offset 0 then offset 1, sets the DAC code to {byte0, byte1[7:4]} on the second clock edge after the transaction-end strobe, and the busy flag stays 0.
- R3: A single-byte write to offset 7 sets the steering flag to bit 7 of the byte; a read of offset 7 returns {flag, 7'b0}.
- R4: With the steering flag at 1, a legal DAC-pair write stores the code in the start-up copy and leaves the live DAC code unchanged; reads of offsets 0 and 1 return the start-up copy while the flag is 1 and the live code while it is 0.
- R5: A single-byte write to offset 4 replaces the configuration byte and drives the three select outputs from its fields.
- R6: A write to the start-up copy or the configuration byte raises the busy flag on the second edge after the transaction-end strobe and holds it for exactly WRITE_CYCLES cycles.
- R7: A lone DAC byte, a DAC pair out of order, more than one byte to offset 4, and any byte to offsets 2, 3, 5 or 6 leave all registers and outputs unchanged.
- R8: Any write transaction with a byte or its end strobe seen while the busy flag is 1 is discarded.
- R9: A recall strobe copies the start-up code into the live DAC code on the next edge and clears the steering flag.
- R10: A read returns data one cycle after the read strobe: offset 0 gives code bits 11:4, offset 1 gives code bits 3:0 in bits 7:4 with zeros below, offset 4 the configuration byte, reserved offsets 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write byte strobe |
| wr_off | input | 3 | Register offset of the write byte |
| wr_data | input | 8 | Write byte |
| txn_end | input | 1 | Transaction-end strobe |
| rd_en | input | 1 | Read strobe |
| rd_off | input | 3 | Register offset of the read |
| rd_data | output | 8 | Read data, valid one cycle after rd_en |
| recall | input | 1 | Power-up recall strobe |
| dac_code | output | 12 | Live DAC code |
| vh_sel | output | 3 | Full-scale level select |
| vl_sel | output | 3 | Zero-scale level select |
| step_sel | output | 2 | Up/down step size select |
| wip | output | 1 | Non-volatile write in progress |

## Verification
The bench builds the block with WRITE_CYCLES set to 16 instead of a millisecond-scale count. The programming window therefore closes within a few dozen cycles, so its exact length can be counted. A transaction can also be placed inside the window to show that it is dropped, and then the same register can be read back once the window has closed.

// File: rtl/dac_regbank_pkg.sv
package dac_regbank_pkg;
  localparam int BYTE_W = 8;
  localparam int OFF_W  = 3;
  localparam int CODE_W = 12;

  localparam logic [OFF_W-1:0] OFF_CODE_HI = 3'd0;
  localparam logic [OFF_W-1:0] OFF_CODE_LO = 3'd1;
  localparam logic [OFF_W-1:0] OFF_CFG     = 3'd4;
  localparam logic [OFF_W-1:0] OFF_STEER   = 3'd7;

  localparam logic [BYTE_W-1:0] CFG_RESET = 8'h84;

  typedef enum logic [1:0] {
    CM_NONE  = 2'd0,
    CM_CODE  = 2'd1,
    CM_CFG   = 2'd2,
    CM_STEER = 2'd3
  } commit_e;
endpackage

// File: rtl/dac_regbank_stage.sv
module dac_regbank_stage
  import dac_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              txn_end,
  output commit_e           commit_kind,
  output logic [BYTE_W-1:0] commit_b0,
  output logic [BYTE_W-1:0] commit_b1
);
  localparam int CNT_W = 2;
  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  logic [CNT_W-1:0]  nbytes;
  logic [OFF_W-1:0]  off0, off1;
  logic [BYTE_W-1:0] data0, data1;
  logic              tainted;
  commit_e           verdict;

  always_comb begin
    verdict = CM_NONE;
    if (!tainted && !busy) begin
      if (nbytes == 2'd2 && off0 == OFF_CODE_HI && off1 == OFF_CODE_LO)
        verdict = CM_CODE;
      else if (nbytes == 2'd1 && off0 == OFF_CFG)
        verdict = CM_CFG;
      else if (nbytes == 2'd1 && off0 == OFF_STEER)
        verdict = CM_STEER;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nbytes      <= '0;
      off0        <= '0;
      off1        <= '0;
      data0       <= '0;
      data1       <= '0;
      tainted     <= 1'b0;
      commit_kind <= CM_NONE;
      commit_b0   <= '0;
      commit_b1   <= '0;
    end else begin
      commit_kind <= CM_NONE;
      if (txn_end) begin
        commit_kind <= verdict;
        commit_b0   <= data0;
        commit_b1   <= data1;
        nbytes      <= '0;
        tainted     <= 1'b0;
      end else if (wr_en) begin
        if (busy) tainted <= 1'b1;
        if (nbytes == 2'd0) begin
          off0  <= wr_off;
          data0 <= wr_data;
        end else if (nbytes == 2'd1) begin
          off1  <= wr_off;
          data1 <= wr_data;
        end
        if (nbytes != CNT_SAT) nbytes <= nbytes + 1'b1;
      end
    end
  end

  assert_commit_needs_end_R7: assert property (@(posedge clk) disable iff (rst)
    (commit_kind != CM_NONE) |-> $past(txn_end));

  assert_busy_drops_commit_R8: assert property (@(posedge clk) disable iff (rst)
    (txn_end && busy) |=> (commit_kind == CM_NONE));
endmodule

// File: rtl/dac_regbank_timer.sv
module dac_regbank_timer #(
  parameter int WRITE_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(WRITE_CYCLES - 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      busy   <= 1'b0;
    end else if (start) begin
      remain <= LOAD;
      busy   <= 1'b1;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end else begin
      busy <= 1'b0;
    end
  end

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

  assert_start_raises_R6: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
endmodule

// File: rtl/dac_regbank.sv
module dac_regbank
  import dac_regbank_pkg::*;
#(
  parameter int WRITE_CYCLES = 500000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [2:0]  wr_off,
  input  logic [7:0]  wr_data,
  input  logic        txn_end,
  input  logic        rd_en,
  input  logic [2:0]  rd_off,
  output logic [7:0]  rd_data,
  input  logic        recall,
  output logic [11:0] dac_code,
  output logic [2:0]  vh_sel,
  output logic [2:0]  vl_sel,
  output logic [1:0]  step_sel,
  output logic        wip
);
  localparam int LO_W  = CODE_W - BYTE_W;
  localparam int PAD_W = BYTE_W - LO_W;

  commit_e           kind;
  logic [BYTE_W-1:0] b0, b1;
  logic [CODE_W-1:0] live_q, init_q, shown;
  logic [BYTE_W-1:0] cfg_q;
  logic              steer_q;
  logic              nv_start;

  dac_regbank_stage u_stage (
    .clk(clk), .rst(rst), .busy(wip),
    .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data), .txn_end(txn_end),
    .commit_kind(kind), .commit_b0(b0), .commit_b1(b1)
  );

  assign nv_start = (kind == CM_CFG) || (kind == CM_CODE && steer_q);

  dac_regbank_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(nv_start), .busy(wip)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q  <= '0;
      init_q  <= '0;
      cfg_q   <= CFG_RESET;
      steer_q <= 1'b0;
    end else if (recall) begin
      live_q  <= init_q;
      steer_q <= 1'b0;
    end else begin
      case (kind)
        CM_CODE: begin
          if (steer_q) init_q <= {b0, b1[BYTE_W-1 -: LO_W]};
          else         live_q <= {b0, b1[BYTE_W-1 -: LO_W]};
        end
        CM_CFG:   cfg_q   <= b0;
        CM_STEER: steer_q <= b0[BYTE_W-1];
        default: ;
      endcase
    end
  end

  assign shown = steer_q ? init_q : live_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (rd_off)
        OFF_CODE_HI: rd_data <= shown[CODE_W-1 -: BYTE_W];
        OFF_CODE_LO: rd_data <= {shown[LO_W-1:0], {PAD_W{1'b0}}};
        OFF_CFG:     rd_data <= cfg_q;
        OFF_STEER:   rd_data <= {steer_q, {(BYTE_W-1){1'b0}}};
        default:     rd_data <= '0;
      endcase
    end
  end

  assign dac_code = live_q;
  assign vh_sel   = cfg_q[7:5];
  assign vl_sel   = cfg_q[4:2];
  assign step_sel = cfg_q[1:0];

  assert_live_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!recall && !(kind == CM_CODE && !steer_q)) |=> $stable(dac_code));

  assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (kind != CM_CFG) |=> $stable({vh_sel, vl_sel, step_sel}));

  assert_recall_load_R9: assert property (@(posedge clk) disable iff (rst)
    recall |=> (dac_code == $past(init_q)));

  assert_nv_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (kind == CM_CFG) |=> wip);
endmodule

// File: tb/tb_dac_regbank.sv
module tb_dac_regbank;
  localparam int CLK_PERIOD = 10;
  localparam int WCYC = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_off = '0;
  logic [7:0]  wr_data = '0;
  logic        txn_end = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_off = '0;
  logic [7:0]  rd_data;
  logic        recall = 1'b0;
  logic [11:0] dac_code;
  logic [2:0]  vh_sel, vl_sel;
  logic [1:0]  step_sel;
  logic        wip;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_regbank #(.WRITE_CYCLES(WCYC)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
    .txn_end(txn_end), .rd_en(rd_en), .rd_off(rd_off), .rd_data(rd_data),
    .recall(recall), .dac_code(dac_code), .vh_sel(vh_sel), .vl_sel(vl_sel),
    .step_sel(step_sel), .wip(wip)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: compares read data one cycle after each read strobe
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {24'd0, rd_data}, {24'd0, e});
    end
  end

  task automatic rd(input logic [2:0] off, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_off = off;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wb(input logic [2:0] off, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_off = off; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fin();
    txn_end = 1'b1;
    @(negedge clk);
    txn_end = 1'b0;
    @(negedge clk);
  endtask

  task automatic count_wip(output int n);
    n = 0;
    while (wip && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check("R1 code", dac_code, 12'h000);
    check("R1 vh", vh_sel, 3'b100);
    check("R1 vl", vl_sel, 3'b001);
    check("R1 step", step_sel, 2'b00);
    check("R1 wip", wip, 1'b0);
    rd(3'd4, 8'h84, "R1 cfg read");
    rd(3'd7, 8'h00, "R1 steer read");

    // R2 volatile code write
    wb(3'd0, 8'hA5); wb(3'd1, 8'h3C); fin();
    check("R2 code", dac_code, 12'hA53);
    check("R2 no wip", wip, 1'b0);
    rd(3'd0, 8'hA5, "R10 hi byte");
    rd(3'd1, 8'h30, "R10 lo nibble");
    rd(3'd2, 8'h00, "R10 reserved");

    // R7 illegal patterns
    wb(3'd0, 8'h11); fin();
    check("R7 lone byte", dac_code, 12'hA53);
    wb(3'd1, 8'h22); wb(3'd0, 8'h33); fin();
    check("R7 wrong order", dac_code, 12'hA53);
    wb(3'd0, 8'h44); wb(3'd1, 8'h55); wb(3'd2, 8'h66); fin();
    check("R7 extra byte", dac_code, 12'hA53);
    wb(3'd4, 8'h12); wb(3'd5, 8'h34); fin();
    check("R7 multi cfg", {vh_sel, vl_sel, step_sel}, 8'h84);
    check("R7 multi cfg no wip", wip, 1'b0);
    wb(3'd3, 8'hFF); fin();
    rd(3'd3, 8'h00, "R7 reserved write");
    check("R7 reserved code", dac_code, 12'hA53);

    // R3 steering
    wb(3'd7, 8'h80); fin();
    rd(3'd7, 8'h80, "R3 steer set");

    // R4/R6 stored-copy write
    wb(3'd0, 8'h12); wb(3'd1, 8'hF0); fin();
    check("R4 live kept", dac_code, 12'hA53);
    count_wip(n);
    check("R6 wip length", n, WCYC);
    rd(3'd0, 8'h12, "R4 init hi");
    rd(3'd1, 8'hF0, "R4 init lo");

    // R5 config write, R8 write during busy
    wb(3'd4, 8'hA9); fin();
    check("R6 cfg busy", wip, 1'b1);
    wb(3'd7, 8'h00); fin();
    wb(3'd4, 8'h00); fin();
    idle(WCYC);
    check("R8 idle after", wip, 1'b0);
    rd(3'd7, 8'h80, "R8 steer kept");
    check("R5 vh", vh_sel, 3'b101);
    check("R5 vl", vl_sel, 3'b010);
    check("R5 step", step_sel, 2'b01);

    // R4 steer cleared shows live
    wb(3'd7, 8'h00); fin();
    rd(3'd0, 8'hA5, "R4 live hi");

    // R9 recall
    wb(3'd7, 8'h80); fin();
    @(negedge clk);
    recall = 1'b1;
    @(negedge clk);
    recall = 1'b0;
    check("R9 code", dac_code, 12'h12F);
    rd(3'd7, 8'h00, "R9 steer cleared");

    idle(2);
    check("scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule